// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer

This block holds four independent 32-bit down-counters and one shared interrupt bank, all reached through a plain word-addressed register bus (address, write strobe, write data, combinational read data). Each channel counts down on ticks from its own prescaler. On reaching zero it either stops (one-shot), restarts from a reload value (periodic), or rolls over to all ones (free-running). Because the counters run downwards, software gets elapsed time by inverting the count it reads.

Each channel keeps two values. The load value is applied at once to the counter and to the reload store. The reload value, written on its own, is only used the next time the counter wraps, so the count in progress is not disturbed. Each channel reports zero through one raw status bit. A mask turns raw bits into masked bits, and the masked bits are ORed into a single interrupt line. Raw bits are cleared by writing ones.

Top module: `quad_down_timer`

## Requirements
- R1: After synchronous reset, every register reads zero, every channel is stopped and `irq` is low.
- R12: Word address map: 0 interrupt mask, 1 raw status (read-only), 2 masked status, 3 clear (reads 0). Channel c (0..3) uses addresses 4+4c+k, with k=0 load, k=1 current count (read-only), k=2 control, k=3 reload. Control reads back bits 0, 1, 3:2, 6 and 7, and zero elsewhere. Addresses 20 and up read 0.
- R2: Writing a channel's load register sets its current count and its reload value in the same cycle, and reading the load register returns the value written. Writes to the current-count address are ignored.
- R3: Writing the reload register changes only the reload value. The current count is unaffected.
- R4: With control bit 7 set, the count falls by one on each prescaler tick. A write that clears bit 7 freezes the count from the next cycle on.
- R5: With bit 0 clear and bit 6 set (periodic), a counter at zero reloads from the reload value on its next tick.
- R6: With bit 0 and bit 6 clear (free-running), a counter at zero wraps to all ones for its width. With bit 1 set the full 32 bits count. With bit 1 clear only the low 16 bits count, and the count reads with the upper 16 bits zero.
- R7: When a channel's count steps from 1 to 0, raw status bit c is set after that clock edge.
- R8: Masked status equals raw status AND mask (bit c for channel c). `irq` is high exactly when any masked bit is set.
- R9: Writing 1 to bit c of the clear register clears raw bit c, and writing 0 leaves it unchanged. If a zero event and a clear of the same bit fall in one cycle, the bit stays set.
- R10: With bit 0 set (one-shot), the counter stays at zero until the load register is written again.
- R11: Control bits 3:2 choose the tick rate: 00 every cycle, 01 every 16th cycle, 10 (and 11) every 256th cycle, counted from the cycle the channel was enabled or loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 5 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | OR of the masked status bits |

## Verification
Register writes take effect at the clock edge of the write cycle, and `rdata` reflects the state after that edge with no added latency. The first count step comes one edge after the control write that sets enable, and the count therefore reads L−k k edges later at prescale 1, or L−⌊k/16⌋ at prescale 16. A raw bit and `irq` change at the same edge where the count reaches zero, and the reload or wrap value appears one tick after that. The bench moves one read or write per clock and keeps a running position after each enabling write, so every expected value is worked out for the exact cycle it is sampled in. Each expectation is queued at the falling edge when its address is driven and compared a few nanoseconds later.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int NUM_CH      = 4;
    localparam int DW          = 32;
    localparam int HALF_W      = DW / 2;
    localparam int SHARED_REGS = 4;
    localparam int REGS_PER_CH = 4;
    localparam int NUM_REGS    = SHARED_REGS + NUM_CH * REGS_PER_CH;
    localparam int AW          = $clog2(NUM_REGS);
    localparam int CH_IDX_W    = $clog2(NUM_CH);
    localparam int PRE_W       = 8;

    typedef logic [AW-1:0] addr_t;
    typedef logic [DW-1:0] word_t;

    typedef enum logic [1:0] {
        SH_MASK   = 2'd0,
        SH_RAW    = 2'd1,
        SH_MASKED = 2'd2,
        SH_CLEAR  = 2'd3
    } shared_reg_e;

    typedef enum logic [1:0] {
        CR_LOAD   = 2'd0,
        CR_COUNT  = 2'd1,
        CR_CTRL   = 2'd2,
        CR_RELOAD = 2'd3
    } chan_reg_e;

    typedef enum logic [1:0] {
        PS_1    = 2'd0,
        PS_16   = 2'd1,
        PS_256  = 2'd2,
        PS_256B = 2'd3
    } presc_e;

    typedef struct packed {
        logic   enable;
        logic   periodic;
        presc_e presc;
        logic   wide;
        logic   oneshot;
    } ctrl_t;

    function automatic ctrl_t ctrl_unpack(word_t w);
        ctrl_t c;
        c.oneshot  = w[0];
        c.wide     = w[1];
        c.presc    = presc_e'(w[3:2]);
        c.periodic = w[6];
        c.enable   = w[7];
        return c;
    endfunction

    function automatic word_t ctrl_pack(ctrl_t c);
        word_t w;
        w      = '0;
        w[0]   = c.oneshot;
        w[1]   = c.wide;
        w[3:2] = c.presc;
        w[6]   = c.periodic;
        w[7]   = c.enable;
        return w;
    endfunction

    function automatic logic [PRE_W-1:0] presc_limit(presc_e p);
        case (p)
            PS_1:    return '0;
            PS_16:   return PRE_W'(15);
            default: return PRE_W'(255);
        endcase
    endfunction

    function automatic word_t width_mask(logic wide);
        return wide ? '1 : word_t'({HALF_W{1'b1}});
    endfunction

    function automatic addr_t chan_addr(int ch, chan_reg_e r);
        return addr_t'(SHARED_REGS + ch * REGS_PER_CH + int'(r));
    endfunction

endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_load,
    input  logic  wr_ctrl,
    input  logic  wr_reload,
    input  word_t wdata,
    output word_t load_rd,
    output word_t count_rd,
    output word_t ctrl_rd,
    output word_t reload_rd,
    output logic  zero_hit,
    output logic  oneshot_o,
    output logic  wide_o
);

    ctrl_t             ctrl_q;
    word_t             load_q;
    word_t             reload_q;
    word_t             cnt_q;
    logic [PRE_W-1:0]  pre_q;

    word_t             wmask;
    word_t             cnt_eff;
    word_t             cnt_next;
    logic              at_zero;
    logic              tick;
    logic [PRE_W-1:0]  pre_lim;

    always_comb begin
        wmask   = width_mask(ctrl_q.wide);
        cnt_eff = cnt_q & wmask;
        at_zero = (cnt_eff == '0);
        pre_lim = presc_limit(ctrl_q.presc);
        tick    = ctrl_q.enable && (pre_q >= pre_lim);

        if (!at_zero) begin
            cnt_next = cnt_eff - word_t'(1);
        end else if (ctrl_q.oneshot) begin
            cnt_next = cnt_eff;
        end else if (ctrl_q.periodic) begin
            cnt_next = reload_q & wmask;
        end else begin
            cnt_next = wmask;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            load_q   <= '0;
            reload_q <= '0;
            cnt_q    <= '0;
            pre_q    <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q <= ctrl_unpack(wdata);
            end
            if (wr_reload) begin
                reload_q <= wdata;
            end
            if (wr_load) begin
                load_q   <= wdata;
                reload_q <= wdata;
                cnt_q    <= wdata;
            end else if (tick) begin
                cnt_q <= cnt_next;
            end
            if (wr_load || !ctrl_q.enable || tick) begin
                pre_q <= '0;
            end else begin
                pre_q <= pre_q + PRE_W'(1);
            end
        end
    end

    assign zero_hit  = tick && !wr_load && (cnt_eff == word_t'(1));
    assign load_rd   = load_q;
    assign count_rd  = cnt_eff;
    assign ctrl_rd   = ctrl_pack(ctrl_q);
    assign reload_rd = reload_q;
    assign oneshot_o = ctrl_q.oneshot;
    assign wide_o    = ctrl_q.wide;

endmodule

// File: rtl/tmr_irq_bank.sv
module tmr_irq_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_mask,
    input  logic         wr_clear,
    input  logic [N-1:0] wbits,
    input  logic [N-1:0] hit,
    output logic [N-1:0] mask_q,
    output logic [N-1:0] raw_q,
    output logic         irq
);

    logic [N-1:0] clr_bits;

    assign clr_bits = wr_clear ? wbits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            raw_q  <= '0;
        end else begin
            if (wr_mask) begin
                mask_q <= wbits;
            end
            raw_q <= (raw_q & ~clr_bits) | hit;
        end
    end

    assign irq = |(raw_q & mask_q);

endmodule

// File: rtl/tmr_bus_decode.sv
module tmr_bus_decode
    import tmr_pkg::*;
(
    input  logic                         wr_en,
    input  addr_t                        addr,
    input  logic [NUM_CH-1:0]            mask_q,
    input  logic [NUM_CH-1:0]            raw_q,
    input  logic [NUM_CH-1:0][DW-1:0]    load_rd,
    input  logic [NUM_CH-1:0][DW-1:0]    count_rd,
    input  logic [NUM_CH-1:0][DW-1:0]    ctrl_rd,
    input  logic [NUM_CH-1:0][DW-1:0]    reload_rd,
    output logic                         wr_mask,
    output logic                         wr_clear,
    output logic [NUM_CH-1:0]            wr_load,
    output logic [NUM_CH-1:0]            wr_ctrl,
    output logic [NUM_CH-1:0]            wr_reload,
    output word_t                        rdata
);

    logic                shared_sel;
    logic                in_chan;
    addr_t               rel;
    logic [CH_IDX_W-1:0] ch_idx;
    chan_reg_e           reg_sel;
    shared_reg_e         sh_sel;

    assign shared_sel = (addr < addr_t'(SHARED_REGS));
    assign in_chan    = !shared_sel && (addr < addr_t'(NUM_REGS));
    assign rel        = addr - addr_t'(SHARED_REGS);
    assign ch_idx     = CH_IDX_W'(rel >> 2);
    assign reg_sel    = chan_reg_e'(rel[1:0]);
    assign sh_sel     = shared_reg_e'(addr[1:0]);

    assign wr_mask  = wr_en && shared_sel && (sh_sel == SH_MASK);
    assign wr_clear = wr_en && shared_sel && (sh_sel == SH_CLEAR);

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_strobe
            logic chan_hit;
            assign chan_hit     = wr_en && in_chan && (ch_idx == CH_IDX_W'(c));
            assign wr_load[c]   = chan_hit && (reg_sel == CR_LOAD);
            assign wr_ctrl[c]   = chan_hit && (reg_sel == CR_CTRL);
            assign wr_reload[c] = chan_hit && (reg_sel == CR_RELOAD);
        end
    endgenerate

    always_comb begin
        rdata = '0;
        if (shared_sel) begin
            case (sh_sel)
                SH_MASK:   rdata = word_t'(mask_q);
                SH_RAW:    rdata = word_t'(raw_q);
                SH_MASKED: rdata = word_t'(raw_q & mask_q);
                default:   rdata = '0;
            endcase
        end else if (in_chan) begin
            case (reg_sel)
                CR_LOAD:   rdata = load_rd[ch_idx];
                CR_COUNT:  rdata = count_rd[ch_idx];
                CR_CTRL:   rdata = ctrl_rd[ch_idx];
                default:   rdata = reload_rd[ch_idx];
            endcase
        end
    end

endmodule

// File: rtl/quad_down_timer.sv
module quad_down_timer
    import tmr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          irq
);

    logic [NUM_CH-1:0][DW-1:0] ch_load_rd;
    logic [NUM_CH-1:0][DW-1:0] ch_count_rd;
    logic [NUM_CH-1:0][DW-1:0] ch_ctrl_rd;
    logic [NUM_CH-1:0][DW-1:0] ch_reload_rd;
    logic [NUM_CH-1:0]         ch_hit;
    logic [NUM_CH-1:0]         ch_oneshot;
    logic [NUM_CH-1:0]         ch_wide;
    logic [NUM_CH-1:0]         wr_load;
    logic [NUM_CH-1:0]         wr_ctrl;
    logic [NUM_CH-1:0]         wr_reload;
    logic [NUM_CH-1:0]         irq_mask;
    logic [NUM_CH-1:0]         irq_raw;
    logic                      wr_mask;
    logic                      wr_clear;

    tmr_bus_decode u_decode (
        .wr_en     (wr_en),
        .addr      (addr),
        .mask_q    (irq_mask),
        .raw_q     (irq_raw),
        .load_rd   (ch_load_rd),
        .count_rd  (ch_count_rd),
        .ctrl_rd   (ch_ctrl_rd),
        .reload_rd (ch_reload_rd),
        .wr_mask   (wr_mask),
        .wr_clear  (wr_clear),
        .wr_load   (wr_load),
        .wr_ctrl   (wr_ctrl),
        .wr_reload (wr_reload),
        .rdata     (rdata)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
            tmr_channel u_chan (
                .clk       (clk),
                .rst       (rst),
                .wr_load   (wr_load[c]),
                .wr_ctrl   (wr_ctrl[c]),
                .wr_reload (wr_reload[c]),
                .wdata     (wdata),
                .load_rd   (ch_load_rd[c]),
                .count_rd  (ch_count_rd[c]),
                .ctrl_rd   (ch_ctrl_rd[c]),
                .reload_rd (ch_reload_rd[c]),
                .zero_hit  (ch_hit[c]),
                .oneshot_o (ch_oneshot[c]),
                .wide_o    (ch_wide[c])
            );
        end
    endgenerate

    tmr_irq_bank #(.N(NUM_CH)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .wr_mask  (wr_mask),
        .wr_clear (wr_clear),
        .wbits    (wdata[NUM_CH-1:0]),
        .hit      (ch_hit),
        .mask_q   (irq_mask),
        .raw_q    (irq_raw),
        .irq      (irq)
    );

endmodule

// File: rtl/quad_down_timer_chk.sv
module quad_down_timer_chk
    import tmr_pkg::*;
(
    input logic                      clk,
    input logic                      rst,
    input logic                      wr_en,
    input addr_t                     addr,
    input word_t                     wdata,
    input logic                      irq,
    input logic [NUM_CH-1:0]         hit,
    input logic [NUM_CH-1:0]         raw_st,
    input logic [NUM_CH-1:0]         mask_st,
    input logic [NUM_CH-1:0]         oneshot,
    input logic [NUM_CH-1:0]         wide,
    input logic [NUM_CH-1:0][DW-1:0] cnt
);

    localparam addr_t CLR_A = addr_t'(SH_CLEAR);

    logic              clr_wr;
    logic [NUM_CH-1:0] clr_bits;

    assign clr_wr   = wr_en && (addr == CLR_A);
    assign clr_bits = clr_wr ? wdata[NUM_CH-1:0] : '0;

    AST_HIT_SETS_RAW: assert property (@(posedge clk) disable iff (rst)
        (hit != '0) |=> ((raw_st & $past(hit)) == $past(hit))); // R7

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
        ((clr_bits & ~hit) != '0) |=> ((raw_st & $past(clr_bits & ~hit)) == '0)); // R9

    AST_RAW_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((clr_bits == '0) && (hit == '0)) |=> $stable(raw_st)); // R9

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
        irq |-> (mask_st != '0)); // R8

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            localparam addr_t LD_A = chan_addr(c, CR_LOAD);
            localparam addr_t CT_A = chan_addr(c, CR_CTRL);

            AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (rst)
                (oneshot[c] && (cnt[c] == '0) && !(wr_en && (addr == LD_A))
                 && !(wr_en && (addr == CT_A))) |=> (cnt[c] == '0)); // R10

            AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
                (wr_en && (addr == LD_A)) |=>
                (cnt[c] == ($past(wdata) & width_mask($past(wide[c]))))); // R2
        end
    endgenerate

endmodule

bind quad_down_timer quad_down_timer_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .irq     (irq),
    .hit     (ch_hit),
    .raw_st  (irq_raw),
    .mask_st (irq_mask),
    .oneshot (ch_oneshot),
    .wide    (ch_wide),
    .cnt     (ch_count_rd)
);

// File: tb/quad_down_timer_bench.sv
`timescale 1ns/1ps
module quad_down_timer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [31:0] exp;
        bit          is_irq;
        logic [4:0]  a;
        string       req;
    } item_t;

    item_t sb_q[$];

    always #10 clk = ~clk;

    quad_down_timer u_quad_down_timer (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq)
    );

    function automatic int ca(int ch, int k);
        return 4 + 4 * ch + k;
    endfunction

    task automatic wr(input int a, input logic [31:0] d);
        addr  = 5'(a);
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, input logic [31:0] e, input string r);
        item_t it;
        addr      = 5'(a);
        it.exp    = e;
        it.is_irq = 1'b0;
        it.a      = 5'(a);
        it.req    = r;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic irq_is(input logic e, input string r);
        item_t it;
        it.exp    = {31'b0, e};
        it.is_irq = 1'b1;
        it.a      = addr;
        it.req    = r;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: compares each queued expectation shortly after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            #4;
            while (sb_q.size() > 0) begin
                item_t       it;
                logic [31:0] act;
                it  = sb_q.pop_front();
                act = it.is_irq ? {31'b0, irq} : rdata;
                tests++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s %s addr=%0d actual=%h expected=%h",
                             it.req, it.is_irq ? "irq" : "rdata", it.a, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state, R12 map
        rd(ca(0, 2), 32'h0, "R1");
        rd(ca(0, 1), 32'h0, "R1");
        rd(1, 32'h0, "R1");
        irq_is(1'b0, "R1");
        rd(25, 32'h0, "R12");

        // R2 load sets count and reload
        wr(ca(0, 0), 32'd5);
        rd(ca(0, 1), 32'd5, "R2");
        rd(ca(0, 3), 32'd5, "R2");
        rd(ca(0, 0), 32'd5, "R2");

        // R3 reload write leaves count alone
        wr(ca(0, 3), 32'd9);
        rd(ca(0, 1), 32'd5, "R3");
        rd(ca(0, 3), 32'd9, "R3");

        // periodic, 32-bit, prescale 1, enabled
        wr(ca(0, 2), 32'hC2);
        rd(ca(0, 2), 32'hC2, "R12");         // j0
        rd(ca(0, 1), 32'd4, "R4");           // j1
        rd(ca(0, 1), 32'd3, "R4");           // j2
        rd(ca(0, 1), 32'd2, "R4");           // j3
        rd(ca(0, 1), 32'd1, "R4");           // j4
        rd(1, 32'h1, "R7");                  // j5
        rd(ca(0, 1), 32'd9, "R5");           // j6
        wr(ca(0, 2), 32'h0);                 // j7, edge still ticks 8->7
        rd(ca(0, 1), 32'd7, "R4");
        rd(ca(0, 1), 32'd7, "R4");

        // R8 masking, R9 clearing
        rd(2, 32'h0, "R8");
        irq_is(1'b0, "R8");
        wr(0, 32'h1);
        rd(0, 32'h1, "R8");
        rd(2, 32'h1, "R8");
        irq_is(1'b1, "R8");
        wr(3, 32'h0);
        rd(1, 32'h1, "R9");
        wr(3, 32'h1);
        rd(1, 32'h0, "R9");
        irq_is(1'b0, "R9");
        rd(3, 32'h0, "R12");

        // R6 16-bit free-running wrap on channel 1
        wr(ca(1, 0), 32'd2);
        wr(ca(1, 2), 32'h80);
        rd(ca(1, 1), 32'd2, "R6");           // j0
        rd(ca(1, 1), 32'd1, "R6");           // j1
        rd(ca(1, 1), 32'd0, "R6");           // j2
        rd(ca(1, 1), 32'h0000FFFF, "R6");    // j3
        rd(ca(1, 1), 32'h0000FFFE, "R6");    // j4
        wr(ca(1, 2), 32'h0);                 // j5
        rd(ca(1, 1), 32'h0000FFFC, "R4");
        wr(ca(1, 0), 32'h12340003);
        rd(ca(1, 1), 32'h00000003, "R6");
        wr(ca(1, 1), 32'h55);
        rd(ca(1, 1), 32'h00000003, "R2");
        rd(ca(1, 0), 32'h12340003, "R2");
        rd(1, 32'h2, "R7");
        irq_is(1'b0, "R8");

        // R6 32-bit free-running wrap on channel 2
        wr(ca(2, 0), 32'd1);
        wr(ca(2, 2), 32'h82);
        rd(ca(2, 1), 32'd1, "R6");
        rd(ca(2, 1), 32'd0, "R6");
        rd(ca(2, 1), 32'hFFFFFFFF, "R6");
        wr(ca(2, 2), 32'h0);

        // R10 one-shot on channel 3, R9 set beats clear
        wr(ca(3, 0), 32'd2);
        wr(ca(3, 2), 32'h83);
        rd(ca(3, 1), 32'd2, "R10");          // j0
        rd(ca(3, 1), 32'd1, "R10");          // j1
        rd(ca(3, 1), 32'd0, "R10");          // j2
        rd(ca(3, 1), 32'd0, "R10");          // j3
        rd(ca(3, 1), 32'd0, "R10");          // j4
        rd(1, 32'hE, "R7");                  // j5
        wr(ca(3, 0), 32'd3);                 // j6
        rd(ca(3, 1), 32'd3, "R10");          // j7
        wr(3, 32'h8);                        // j8, edge 2->1
        wr(3, 32'h8);                        // j9, edge 1->0 with clear
        rd(1, 32'hE, "R9");
        wr(0, 32'hF);
        rd(2, 32'hE, "R8");
        irq_is(1'b1, "R8");

        // R11 prescale 16 on channel 0
        wr(ca(0, 0), 32'd3);
        wr(ca(0, 2), 32'h86);
        idle(15);
        rd(ca(0, 1), 32'd3, "R11");
        rd(ca(0, 1), 32'd2, "R11");

        // R11 prescale 256 on channel 2
        wr(ca(2, 0), 32'd2);
        wr(ca(2, 2), 32'h8A);
        idle(255);
        rd(ca(2, 1), 32'd2, "R11");
        rd(ca(2, 1), 32'd1, "R11");

        idle(2);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule